// File: doc/BRIEF.md
# Paged Sparse Single-Port Memory

This block is a clocked single-port memory whose logical address space is far larger than its physical storage. The address is split into a logical page number and a word offset. Physical storage is a small pool of page frames, and a frame is bound to a logical page only when that page receives its first write. Every physical word carries a written flag, so the block can tell a stored value from a location that was never written.

A request strobe qualifies each operation, and a read-not-write input selects its direction. A write stores in the same clock edge that accepts it. A read returns its data a parameterised number of cycles later, together with a flag that marks the data as unknown when the word was never written. While a read is in flight the block reports busy and ignores new requests. A single deallocate input unmaps every page and forgets every written word at once.

Top module: `paged_sparse_mem`

## Requirements
- R1: A write (req=1, rnw=0, accepted) stores wdata at addr, and a later read of addr returns that word with rinvalid=0.
- R2: An accepted read (req=1, rnw=1, busy=0, dealloc=0) raises rvalid for exactly one cycle, RD_LAT rising edges after the edge that accepts it; rvalid stays 0 in between.
- R3: A read of a word that was never written, inside a page that is mapped, returns rinvalid=1 and rdata driven to X.
- R4: A read from an unmapped page returns rinvalid=1 and does not take a frame from the pool.
- R5: The first write to an unmapped page binds a free frame to it, so FRAMES distinct logical pages can hold data at the same time.
- R6: A write to an unmapped page when all FRAMES frames are in use is dropped and sets overflow; writes to already mapped pages keep working.
- R7: A cycle with dealloc=1 unmaps every page and clears every written flag: all locations then read with rinvalid=1, and FRAMES new pages can be mapped again.
- R8: While busy=1 (a read pending) any request is ignored; a write attempted then leaves memory unchanged.
- R9: After reset rvalid, busy and overflow are 0 and every location reads with rinvalid=1.
- R10: A request presented in the same cycle as dealloc=1 is ignored.
- R11: overflow, once set, stays at 1 until reset; dealloc does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operation request strobe |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address: upper bits page, lower PAGE_BITS offset |
| wdata | input | DW | Write data |
| dealloc | input | 1 | Release all pages and written flags |
| rdata | output | DW | Read data, X when the word is unwritten |
| rvalid | output | 1 | One-cycle pulse when rdata and rinvalid are valid |
| rinvalid | output | 1 | Read returned a never-written location |
| busy | output | 1 | A read is pending; requests are ignored |
| overflow | output | 1 | Sticky: a write found the frame pool exhausted |

## Verification
A corrupted page map shows at the ports as read data coming back from the wrong logical page, or as a stored word reported invalid, on the very first read-back after the write. A frame counter that drifts shows either as overflow rising one page too early or too late, or as a fresh page reading another page's data. Written flags that survive deallocation appear as rinvalid=0 on the first read after dealloc, and a broken latency counter moves the rvalid pulse off its expected edge or lets a request slip in while busy.

// File: rtl/paged_sparse_mem.sv
module paged_sparse_mem #(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int PAGE_BITS = 4,
  parameter int FRAMES    = 4,
  parameter int RD_LAT    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          dealloc,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          rinvalid,
  output logic          busy,
  output logic          overflow
);
  localparam int NPAGES = 1 << (AW - PAGE_BITS);
  localparam int PWORDS = 1 << PAGE_BITS;
  localparam int WORDS  = FRAMES * PWORDS;
  localparam int FW     = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int UW     = $clog2(FRAMES + 1);
  localparam int CW     = $clog2(RD_LAT + 1);
  localparam int IW     = FW + PAGE_BITS;

  logic [DW-1:0]     mem  [WORDS];
  logic [FW-1:0]     pmap [NPAGES];
  logic [WORDS-1:0]  written;
  logic [NPAGES-1:0] mapped;
  logic [UW-1:0]     used;
  logic [CW-1:0]     cnt;
  logic              hold_hit;
  logic [DW-1:0]     hold_data;

  wire [AW-PAGE_BITS-1:0] page = addr[AW-1:PAGE_BITS];
  wire [PAGE_BITS-1:0]    off  = addr[PAGE_BITS-1:0];
  wire          take      = req && !busy && !dealloc;
  wire          pool_open = used < UW'(FRAMES);
  wire [FW-1:0] frame     = mapped[page] ? pmap[page] : used[FW-1:0];
  wire [IW-1:0] idx       = {frame, off};
  wire          do_wr     = take && !rnw && (mapped[page] || pool_open);
  wire          do_map    = take && !rnw && !mapped[page] && pool_open;

  assign busy = cnt != '0;

  always_ff @(posedge clk) begin
    if (do_wr) mem[idx] <= wdata;
    if (do_map) pmap[page] <= used[FW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped    <= '0;
      written   <= '0;
      used      <= '0;
      overflow  <= 1'b0;
      cnt       <= '0;
      hold_hit  <= 1'b0;
      hold_data <= '0;
      rvalid    <= 1'b0;
      rinvalid  <= 1'b0;
      rdata     <= '0;
    end else begin
      rvalid <= 1'b0;
      if (dealloc) begin
        mapped  <= '0;
        written <= '0;
        used    <= '0;
      end else if (take && !rnw) begin
        if (do_wr) written[idx] <= 1'b1;
        if (do_map) begin
          mapped[page] <= 1'b1;
          used         <= used + UW'(1);
        end
        if (!do_wr) overflow <= 1'b1;
      end
      if (take && rnw) begin
        cnt       <= CW'(RD_LAT);
        hold_hit  <= mapped[page] && written[idx];
        hold_data <= mem[idx];
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          rvalid   <= 1'b1;
          rinvalid <= !hold_hit;
          rdata    <= hold_hit ? hold_data : {DW{1'bx}};
        end
      end
    end
  end

  assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  assert_valid_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(busy));
  assert_pool_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    used <= UW'(FRAMES));
  assert_overflow_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(used) == UW'(FRAMES));
  assert_dealloc_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dealloc) |-> (used == '0 && mapped == '0 && written == '0));
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dealloc) |=> ($stable(used) && $stable(mapped) && $stable(written)));
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/test_paged_sparse_mem.sv
`timescale 1ns/1ps
module test_paged_sparse_mem;
  localparam int LAT = 2;
  localparam int NV  = 12;
  // {op(1=read), addr[7:0], data[15:0], expect_invalid}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h10, 16'hA001, 1'b0}, {1'b0, 8'h1F, 16'hA00F, 1'b0},
    {1'b0, 8'h50, 16'h5000, 1'b0}, {1'b0, 8'h57, 16'h5007, 1'b0},
    {1'b0, 8'h11, 16'hA011, 1'b0}, {1'b1, 8'h10, 16'hA001, 1'b0},
    {1'b1, 8'h11, 16'hA011, 1'b0}, {1'b1, 8'h1F, 16'hA00F, 1'b0},
    {1'b1, 8'h50, 16'h5000, 1'b0}, {1'b1, 8'h57, 16'h5007, 1'b0},
    {1'b1, 8'h12, 16'h0000, 1'b1}, {1'b1, 8'h30, 16'h0000, 1'b1}
  };

  logic clk = 0, rst_n = 0, req = 0, rnw = 0, dealloc = 0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid, rinvalid, busy, overflow;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  paged_sparse_mem #(.DW(16), .AW(8), .PAGE_BITS(4), .FRAMES(4), .RD_LAT(LAT)) i_paged_sparse_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .rnw(rnw), .addr(addr), .wdata(wdata),
    .dealloc(dealloc), .rdata(rdata), .rvalid(rvalid), .rinvalid(rinvalid),
    .busy(busy), .overflow(overflow));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; rnw = 0; addr = a; wdata = d;
    @(negedge clk); req = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input bit inv, input string tag);
    @(negedge clk); req = 1; rnw = 1; addr = a;
    @(posedge clk); #1 req = 0;
    for (int i = 1; i <= LAT; i++) begin
      @(posedge clk); #1;
      if (i < LAT) chk(rvalid == 0, "R2 early rvalid", 32'(rvalid), 0);
      else begin
        chk(rvalid == 1, "R2 rvalid", 32'(rvalid), 1);
        chk(rinvalid == inv, tag, 32'(rinvalid), 32'(inv));
        if (!inv) chk(rdata == exp, tag, 32'(rdata), 32'(exp));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    chk(rvalid == 0 && busy == 0 && overflow == 0, "R9 reset outputs",
        {29'b0, rvalid, busy, overflow}, 0);
    rd(8'h00, 16'h0, 1, "R9 read after reset");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][25]) rd(VEC[v][24:17], VEC[v][16:1], VEC[v][0], "R1/R3/R4 vector read");
      else wr(VEC[v][24:17], VEC[v][16:1]);
    end

    // R8: write attempted while a read is pending (LAT=2)
    @(negedge clk); req = 1; rnw = 1; addr = 8'h10;
    @(posedge clk); #1;
    chk(busy == 1, "R8 busy", 32'(busy), 1);
    rnw = 0; wdata = 16'hFFFF;
    @(posedge clk); #1 req = 0;
    chk(rvalid == 0, "R2 early rvalid", 32'(rvalid), 0);
    @(posedge clk); #1;
    chk(rvalid == 1 && rdata == 16'hA001, "R8 pending read", 32'(rdata), 32'hA001);
    rd(8'h10, 16'hA001, 0, "R8 write during busy ignored");

    // R4/R5: two more pages fit only if unmapped reads took no frames
    wr(8'h20, 16'h2222);
    wr(8'h30, 16'h3333);
    chk(overflow == 0, "R4 no frame taken by reads", 32'(overflow), 0);
    rd(8'h20, 16'h2222, 0, "R5 third page");
    rd(8'h30, 16'h3333, 0, "R5 fourth page");

    // R6: pool exhausted
    wr(8'h90, 16'h9999);
    chk(overflow == 1, "R6 overflow set", 32'(overflow), 1);
    rd(8'h90, 16'h0, 1, "R6 dropped write");
    wr(8'h21, 16'h2121);
    rd(8'h21, 16'h2121, 0, "R6 mapped page still writable");

    // R10/R7: dealloc with a concurrent write
    @(negedge clk); dealloc = 1; req = 1; rnw = 0; addr = 8'h40; wdata = 16'h4444;
    @(negedge clk); dealloc = 0; req = 0;
    chk(overflow == 1, "R11 overflow kept after dealloc", 32'(overflow), 1);
    rd(8'h40, 16'h0, 1, "R10 request with dealloc ignored");
    rd(8'h10, 16'h0, 1, "R7 page 1 released");
    rd(8'h50, 16'h0, 1, "R7 page 5 released");
    rd(8'h21, 16'h0, 1, "R7 page 2 released");
    wr(8'h60, 16'h6666);
    wr(8'h70, 16'h7777);
    wr(8'h80, 16'h8888);
    wr(8'h90, 16'h9090);
    rd(8'h60, 16'h6666, 0, "R7 new page after dealloc");
    rd(8'h70, 16'h7777, 0, "R7 new page after dealloc");
    rd(8'h80, 16'h8888, 0, "R7 new page after dealloc");
    rd(8'h90, 16'h9090, 0, "R7 fourth page after dealloc");
    rd(8'h91, 16'h0, 1, "R3 unwritten word in new page");
    chk(overflow == 1, "R11 overflow sticky", 32'(overflow), 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule